// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the host side of an asynchronous byte-wide flash device. It takes one request at a time: program one byte, erase one sector, or erase the whole array. For each request it plays out the fixed unlock and command write sequence on the bus. Every write cycle is timed by clock counters, so the write-enable low time, the high time and the total cycle length meet the device minimums for the configured clock period.

After the last command write the block releases the data bus. It then polls the device with timed output-enable reads, watching the single status bit that the device returns on data line 7. While an embedded program runs, that bit is the complement of the bit being written. While an erase runs, the bit reads 0, and it reads 1 once the erase is complete.

When the status bit matches the expected value, the block pulses `done`. If a configured number of reads pass without a match, it pulses `done` together with `error`. The companion static RAM that shares the bus is kept deselected at all times.

Top module: `flash_cmd_seq`

## Requirements
- R1: Request kind 2'b00 (byte program) issues exactly four bus writes, as address/data pairs: 5555h/AAh, 2AAAh/55h, 5555h/A0h, then the target address with the request byte.
- R2: Request kind 2'b01 (sector erase) issues six bus writes: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, then 30h at the sector base. The sector base keeps the top 3 bits of the 19-bit request address and clears the lower 16 bits.
- R3: Request kind 2'b10 (full-chip erase) issues the same first five writes as R2, then a sixth write of 10h at 5555h.
- R4: In each write cycle, `fl_we_n` is low for ceil(50 ns / clock period) cycles. Consecutive write-enable falling edges within one request are max(ceil(120/T), low cycles + ceil(20/T)) cycles apart, where T is the clock period in ns. Address and data do not change while write-enable is low or at its rising edge.
- R5: After the last write, the block polls with reads: `fl_oe_n` is low, `fl_drive` is low and `fl_we_n` is high. A program is polled at its target address, a sector erase at its sector base and a chip erase at address 0.
- R6: Polling completes when data line 7 equals the expected value: bit 7 of the request byte for a program, or 1 for either erase. On completion `done` pulses for one cycle with `error` low, and no earlier than the device finishes.
- R7: If POLL_LIMIT reads pass without a match, the block stops polling. After exactly POLL_LIMIT reads it pulses `done` and `error` together for one cycle.
- R8: `sram_ce_n` is high at all times.
- R9: Request kind 2'b11 is ignored: no bus cycle, `busy` stays low. Any request made while `busy` is high is also ignored.
- R10: After reset `busy`, `done`, `error` and `fl_drive` are low, and `fl_ce_n`, `fl_we_n` and `fl_oe_n` are high. `busy` is high from the cycle after a request is accepted until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_kind | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 reserved |
| req_addr | input | 19 | Target byte address |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | High with `done` when polling timed out |
| fl_addr | output | 19 | Flash address |
| fl_dout | output | 8 | Flash write data |
| fl_d7 | input | 1 | Data line 7 read back from the flash |
| fl_ce_n | output | 1 | Flash chip select, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_drive | output | 1 | High when the host drives the data bus |
| sram_ce_n | output | 1 | Companion RAM select, held high |

## Verification
The bench runs two byte programs, one with request bit 7 clear and one with it set. A block that polls for a fixed polarity finishes early on one of the two and is caught. A sector erase at an address with non-zero sector bits and a chip erase differ only in the final write and in the polling address, so a mixed-up sector base or final command shows up. A flash model that never completes exposes the timeout count. A reserved kind, and a request made in the middle of an operation, confirm that no extra bus writes appear.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'b00,
        OP_SECT = 2'b01,
        OP_CHIP = 2'b10,
        OP_NONE = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_GAP
    } st_e;

    // last step of the write sequence for a given operation
    function automatic logic is_last(op_e op, logic [2:0] step);
        return (op == OP_PROG) ? (step == 3'd3) : (step == 3'd5);
    endfunction

endpackage

// File: rtl/flash_cmd_rom.sv
module flash_cmd_rom
    import flash_seq_pkg::*;
#(
    parameter int AW        = 19,
    parameter int DW        = 8,
    parameter int SECT_BITS = 3
) (
    input  op_e           op,
    input  logic [2:0]    step,
    input  logic [AW-1:0] tgt_addr,
    input  logic [DW-1:0] tgt_data,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [AW-1:0] poll_addr,
    output logic          poll_bit
);
    localparam logic [AW-1:0] UNLK_A = AW'(20'h05555);
    localparam logic [AW-1:0] UNLK_B = AW'(20'h02AAA);
    localparam int            LOW_BITS = AW - SECT_BITS;

    logic [AW-1:0] sect_base;
    assign sect_base = {tgt_addr[AW-1 -: SECT_BITS], {LOW_BITS{1'b0}}};

    always_comb begin
        wr_addr = UNLK_A;
        wr_data = DW'(8'hAA);
        case (step)
            3'd0: begin wr_addr = UNLK_A; wr_data = DW'(8'hAA); end
            3'd1: begin wr_addr = UNLK_B; wr_data = DW'(8'h55); end
            3'd2: begin
                wr_addr = UNLK_A;
                wr_data = (op == OP_PROG) ? DW'(8'hA0) : DW'(8'h80);
            end
            3'd3: begin
                if (op == OP_PROG) begin
                    wr_addr = tgt_addr;
                    wr_data = tgt_data;
                end else begin
                    wr_addr = UNLK_A;
                    wr_data = DW'(8'hAA);
                end
            end
            3'd4: begin wr_addr = UNLK_B; wr_data = DW'(8'h55); end
            default: begin
                if (op == OP_SECT) begin
                    wr_addr = sect_base;
                    wr_data = DW'(8'h30);
                end else begin
                    wr_addr = UNLK_A;
                    wr_data = DW'(8'h10);
                end
            end
        endcase
    end

    always_comb begin
        case (op)
            OP_PROG: begin poll_addr = tgt_addr;  poll_bit = tgt_data[DW-1]; end
            OP_SECT: begin poll_addr = sect_base; poll_bit = 1'b1; end
            default: begin poll_addr = '0;        poll_bit = 1'b1; end
        endcase
    end

endmodule

// File: rtl/flash_poll_eval.sv
module flash_poll_eval #(
    parameter int POLL_LIMIT = 1024,
    parameter int PW         = $clog2(POLL_LIMIT + 1)
) (
    input  logic          status_bit,
    input  logic          expect_bit,
    input  logic [PW-1:0] polls,
    output logic          hit,
    output logic          expired
);
    localparam logic [PW-1:0] LAST_POLL = PW'(POLL_LIMIT - 1);

    assign hit     = (status_bit == expect_bit);
    assign expired = (polls >= LAST_POLL);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int CLK_NS     = 10,
    parameter int WLOW_NS    = 50,
    parameter int WHIGH_NS   = 20,
    parameter int WCYC_NS    = 120,
    parameter int RACC_NS    = 120,
    parameter int RDIS_NS    = 30,
    parameter int POLL_LIMIT = 1024,
    parameter int AW         = 19,
    parameter int DW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dout,
    input  logic          fl_d7,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n,
    output logic          fl_drive,
    output logic          sram_ce_n
);
    localparam int LOW_CYC  = (WLOW_NS + CLK_NS - 1) / CLK_NS;
    localparam int HMIN_CYC = (WHIGH_NS + CLK_NS - 1) / CLK_NS;
    localparam int WMIN_CYC = (WCYC_NS + CLK_NS - 1) / CLK_NS;
    localparam int HIGH_CYC = (WMIN_CYC - LOW_CYC > HMIN_CYC) ? WMIN_CYC - LOW_CYC : HMIN_CYC;
    localparam int WC_CYC   = LOW_CYC + HIGH_CYC;
    localparam int RD_CYC   = (RACC_NS + CLK_NS - 1) / CLK_NS + 1;
    localparam int GAP_CYC  = (RDIS_NS + CLK_NS - 1) / CLK_NS;
    localparam int MAX_CYC  = (WC_CYC > RD_CYC) ? ((WC_CYC > GAP_CYC) ? WC_CYC : GAP_CYC)
                                                : ((RD_CYC > GAP_CYC) ? RD_CYC : GAP_CYC);
    localparam int CW       = $clog2(MAX_CYC + 1);
    localparam int PW       = $clog2(POLL_LIMIT + 1);

    localparam logic [CW-1:0] WC_LAST  = CW'(WC_CYC - 1);
    localparam logic [CW-1:0] RD_LAST  = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CYC - 1);
    localparam logic [CW-1:0] LOW_LIM  = CW'(LOW_CYC);

    typedef struct packed {
        st_e           st;
        op_e           op;
        logic [2:0]    step;
        logic [CW-1:0] cnt;
        logic [PW-1:0] polls;
        logic [AW-1:0] tgt;
        logic [DW-1:0] dat;
        logic [AW-1:0] addr;
        logic [DW-1:0] dout;
        logic          ce_n;
        logic          we_n;
        logic          oe_n;
        logic          drive;
        logic          done;
        logic          err;
    } seq_t;

    seq_t q, n;

    // operation context for the next cycle, feeds the command table
    logic          accept, wr_end, last_q;
    op_e           op_d;
    logic [2:0]    step_d;
    logic [AW-1:0] tgt_d;
    logic [DW-1:0] dat_d;

    always_comb begin
        accept = (q.st == ST_IDLE) && req_valid && (op_e'(req_kind) != OP_NONE);
        wr_end = (q.st == ST_WRITE) && (q.cnt == WC_LAST);
        last_q = is_last(q.op, q.step);
        op_d   = accept ? op_e'(req_kind) : q.op;
        tgt_d  = accept ? req_addr : q.tgt;
        dat_d  = accept ? req_data : q.dat;
        if (accept)
            step_d = 3'd0;
        else if (wr_end && !last_q)
            step_d = q.step + 3'd1;
        else
            step_d = q.step;
    end

    logic [AW-1:0] rom_addr, rom_poll_addr;
    logic [DW-1:0] rom_data;
    logic          rom_poll_bit;

    flash_cmd_rom #(.AW(AW), .DW(DW), .SECT_BITS(3)) u_rom (
        .op        (op_d),
        .step      (step_d),
        .tgt_addr  (tgt_d),
        .tgt_data  (dat_d),
        .wr_addr   (rom_addr),
        .wr_data   (rom_data),
        .poll_addr (rom_poll_addr),
        .poll_bit  (rom_poll_bit)
    );

    logic poll_hit, poll_expired;

    flash_poll_eval #(.POLL_LIMIT(POLL_LIMIT), .PW(PW)) u_poll (
        .status_bit (fl_d7),
        .expect_bit (rom_poll_bit),
        .polls      (q.polls),
        .hit        (poll_hit),
        .expired    (poll_expired)
    );

    always_comb begin
        n       = q;
        n.op    = op_d;
        n.step  = step_d;
        n.tgt   = tgt_d;
        n.dat   = dat_d;
        n.done  = 1'b0;
        n.err   = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    n.st  = ST_WRITE;
                    n.cnt = '0;
                end
            end
            ST_WRITE: begin
                if (wr_end) begin
                    n.cnt = '0;
                    if (last_q) begin
                        n.st    = ST_READ;
                        n.polls = '0;
                    end
                end else begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
            ST_READ: begin
                if (q.cnt == RD_LAST) begin
                    n.cnt = '0;
                    if (poll_hit) begin
                        n.st   = ST_IDLE;
                        n.done = 1'b1;
                    end else if (poll_expired) begin
                        n.st   = ST_IDLE;
                        n.done = 1'b1;
                        n.err  = 1'b1;
                    end else begin
                        n.st    = ST_GAP;
                        n.polls = q.polls + 1'b1;
                    end
                end else begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                if (q.cnt == GAP_LAST) begin
                    n.cnt = '0;
                    n.st  = ST_READ;
                end else begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
        endcase

        // registered bus outputs derived from the next state
        n.ce_n  = !((n.st == ST_WRITE) || (n.st == ST_READ));
        n.we_n  = !((n.st == ST_WRITE) && (n.cnt < LOW_LIM));
        n.oe_n  = (n.st != ST_READ);
        n.drive = (n.st == ST_WRITE);
        case (n.st)
            ST_WRITE: begin n.addr = rom_addr;      n.dout = rom_data; end
            ST_READ,
            ST_GAP:   begin n.addr = rom_poll_addr; n.dout = '0; end
            default:  begin n.addr = '0;            n.dout = '0; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.op    <= OP_PROG;
            q.ce_n  <= 1'b1;
            q.we_n  <= 1'b1;
            q.oe_n  <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign error     = q.err;
    assign fl_addr   = q.addr;
    assign fl_dout   = q.dout;
    assign fl_ce_n   = q.ce_n;
    assign fl_we_n   = q.we_n;
    assign fl_oe_n   = q.oe_n;
    assign fl_drive  = q.drive;
    assign sram_ce_n = 1'b1;

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          error,
    input logic [AW-1:0] fl_addr,
    input logic [DW-1:0] fl_dout,
    input logic          fl_ce_n,
    input logic          fl_we_n,
    input logic          fl_oe_n,
    input logic          fl_drive,
    input logic          sram_ce_n
);
    assert_write_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (fl_drive && !fl_ce_n && fl_oe_n));

    assert_stable_at_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dout)));

    assert_read_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> (!fl_drive && fl_we_n && !fl_ce_n));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_error_only_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    assert_sram_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sram_ce_n);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (fl_ce_n && fl_we_n && fl_oe_n && !fl_drive));

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .fl_addr   (fl_addr),
    .fl_dout   (fl_dout),
    .fl_ce_n   (fl_ce_n),
    .fl_we_n   (fl_we_n),
    .fl_oe_n   (fl_oe_n),
    .fl_drive  (fl_drive),
    .sram_ce_n (sram_ce_n)
);

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
    localparam int CLK_NS   = 10;
    localparam int PLIM     = 8;
    localparam int EXP_LOW  = (50 + CLK_NS - 1) / CLK_NS;
    localparam int EXP_WMIN = (120 + CLK_NS - 1) / CLK_NS;
    localparam int EXP_HMIN = (20 + CLK_NS - 1) / CLK_NS;
    localparam int EXP_WC   = (EXP_WMIN > EXP_LOW + EXP_HMIN) ? EXP_WMIN : EXP_LOW + EXP_HMIN;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic        busy, done, error, fl_ce_n, fl_we_n, fl_oe_n, fl_drive, sram_ce_n;
    logic [18:0] fl_addr;
    logic [7:0]  fl_dout;
    logic        fl_d7;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // flash model state
    int          model_busy = 40;
    logic [7:0]  model_val  = 8'hFF;
    int          busy_left  = 0;
    logic [18:0] log_a [0:15];
    logic [7:0]  log_d [0:15];
    int          n_wr = 0;
    int          n_rd = 0;
    logic [18:0] exp_poll = '0;
    int          bad_poll = 0;
    int          bad_width = 0;
    int          bad_period = 0;
    int          bad_bus = 0;
    int          bad_sram = 0;
    int          low_run = 0;
    int          since_fall = 0;
    bit          fall_valid = 0;
    logic        we_prev = 1'b1;
    logic        oe_prev = 1'b1;
    int          done_seen = 0;
    logic        last_err = 1'b0;
    int          done_busy_left = 0;

    always #(CLK_NS/2) clk = ~clk;

    flash_cmd_seq #(.CLK_NS(CLK_NS), .POLL_LIMIT(PLIM)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
        .error(error), .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_d7(fl_d7),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
        .fl_drive(fl_drive), .sram_ce_n(sram_ce_n)
    );

    // status bit: complement of the final value while the embedded job runs
    assign fl_d7 = (!fl_oe_n && !fl_ce_n) ? ((busy_left > 0) ? ~model_val[7] : model_val[7]) : 1'b0;

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (busy_left > 0) busy_left--;
            since_fall++;
            if (!fl_we_n) low_run++;
            if (we_prev && !fl_we_n) begin
                if (fall_valid && since_fall != EXP_WC) bad_period++;
                since_fall = 0;
                fall_valid = 1;
            end
            if (!we_prev && fl_we_n) begin
                if (low_run != EXP_LOW) bad_width++;
                low_run = 0;
                if (n_wr < 16) begin
                    log_a[n_wr] = fl_addr;
                    log_d[n_wr] = fl_dout;
                end
                n_wr++;
                busy_left = model_busy;
            end
            if (oe_prev && !fl_oe_n) begin
                n_rd++;
                if (fl_addr != exp_poll) bad_poll++;
            end
            if (!fl_oe_n && fl_drive) bad_bus++;
            if (!fl_we_n && !fl_drive) bad_bus++;
            if (sram_ce_n !== 1'b1) bad_sram++;
            if (done) begin
                done_seen++;
                last_err = error;
                done_busy_left = busy_left;
            end
            we_prev = fl_we_n;
            oe_prev = fl_oe_n;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        n_wr = 0; n_rd = 0; bad_poll = 0; bad_width = 0; bad_period = 0;
        fall_valid = 0; low_run = 0;
    endtask

    task automatic issue(input logic [1:0] kind, input logic [18:0] addr, input logic [7:0] data);
        @(negedge clk);
        req_kind = kind; req_addr = addr; req_data = data; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input int limit, output bit got);
        int start = done_seen;
        got = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (done_seen != start) begin got = 1; break; end
        end
    endtask

    task automatic check_seq(input string req, input logic [18:0] ea [6], input logic [7:0] ed [6], input int cnt);
        check(n_wr == cnt, req, n_wr, cnt);
        for (int i = 0; i < cnt; i++) begin
            check(log_a[i] == ea[i], req, log_a[i], ea[i]);
            check(log_d[i] == ed[i], req, log_d[i], ed[i]);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(busy == 0 && done == 0 && error == 0 && fl_drive == 0, "R10", {busy, done, error, fl_drive}, 0);
        check(fl_ce_n && fl_we_n && fl_oe_n, "R10", {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
    endtask

    task automatic t_program(input logic [18:0] a, input logic [7:0] d, input bit poke_busy);
        logic [18:0] ea [6];
        logic [7:0]  ed [6];
        bit got;
        clear_log();
        model_busy = 60; model_val = d; exp_poll = a;
        ea = '{19'h05555, 19'h02AAA, 19'h05555, a, 0, 0};
        ed = '{8'hAA, 8'h55, 8'hA0, d, 0, 0};
        issue(2'b00, a, d);
        check(busy == 1, "R10", busy, 1);
        if (poke_busy) issue(2'b10, 19'h0, 8'h00);   // R9: ignored while busy
        wait_done(4000, got);
        check(got, "R6", got, 1);
        check(last_err == 0, "R6", last_err, 0);
        check(done_busy_left == 0, "R6", done_busy_left, 0);
        check_seq("R1", ea, ed, 4);
        check(bad_poll == 0 && n_rd > 0, "R5", bad_poll, 0);
        check(bad_width == 0, "R4", bad_width, 0);
        check(bad_period == 0, "R4", bad_period, 0);
        @(negedge clk);
        check(busy == 0, "R10", busy, 0);
        if (poke_busy) begin
            repeat (40) @(negedge clk);
            check(n_wr == 4 && busy == 0, "R9", n_wr, 4);
        end
    endtask

    task automatic t_erase(input bit chip, input logic [18:0] a);
        logic [18:0] ea [6];
        logic [7:0]  ed [6];
        logic [18:0] base;
        bit got;
        clear_log();
        base = {a[18:16], 16'h0};
        model_busy = 50; model_val = 8'hFF;
        exp_poll = chip ? 19'h0 : base;
        ea = '{19'h05555, 19'h02AAA, 19'h05555, 19'h05555, 19'h02AAA, chip ? 19'h05555 : base};
        ed = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, chip ? 8'h10 : 8'h30};
        issue(chip ? 2'b10 : 2'b01, a, 8'h00);
        wait_done(4000, got);
        check(got && last_err == 0, "R6", last_err, 0);
        check(done_busy_left == 0, "R6", done_busy_left, 0);
        check_seq(chip ? "R3" : "R2", ea, ed, 6);
        check(bad_poll == 0, "R5", bad_poll, 0);
        check(bad_period == 0 && bad_width == 0, "R4", bad_period + bad_width, 0);
    endtask

    task automatic t_timeout();
        bit got;
        clear_log();
        model_busy = 100000; model_val = 8'hFF; exp_poll = 19'h0;
        issue(2'b10, 19'h12345, 8'h00);
        wait_done(6000, got);
        check(got && last_err == 1, "R7", last_err, 1);
        check(n_rd == PLIM, "R7", n_rd, PLIM);
        busy_left = 0;
    endtask

    task automatic t_reserved();
        clear_log();
        issue(2'b11, 19'h05555, 8'hAA);
        check(busy == 0, "R9", busy, 0);
        repeat (30) @(negedge clk);
        check(n_wr == 0 && busy == 0, "R9", n_wr, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program(19'h1F0A3, 8'h3C, 1'b0);
        t_program(19'h60001, 8'hC5, 1'b1);
        t_erase(1'b0, 19'h5ABCD);
        t_erase(1'b1, 19'h7FFFF);
        t_timeout();
        t_reserved();
        check(bad_bus == 0, "R5", bad_bus, 0);
        check(bad_sram == 0, "R8", bad_sram, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule